// File: doc/BRIEF.md
# Display Power Sequencer

This block brings a parallel RGB panel up and down in four ordered stages: pixel clock, sync generation, the display-enable pin and the backlight PWM. Software drives two write-one strobe vectors, one to enable and one to disable, with one bit per stage. It then polls a four-bit status vector until the bit for the stage it commanded reaches the expected level. In both vectors, bit 0 is the pixel clock, bit 1 is sync, bit 2 is the display pin and bit 3 is the PWM.

The block refuses any enable whose predecessor stage is not both commanded and confirmed running. A disable takes every later stage down with it. The display pin waits a programmable number of frames after sync starts, counted on frame-end pulses from the timing generator. A sync disable lets the current frame finish before sync stops. The timing generator, pixel DMA and PWM duty logic lie outside the block: it only drives their enables and watches the frame-end pulse.

Top module: `disp_power_seq`

## Requirements
- R1: After reset, all four stage outputs (`pixClkEn`, `syncEn`, `dispOut`, `pwmEn`) and all `status` bits are 0.
- R2: A clock enable (enSet bit 0) sampled at edge k raises `pixClkEn` at edge k. Clock status (`status` bit 0) follows `pixClkEn`, rising and falling two edges later.
- R3: An enable for stage i > 0 is ignored unless stage i-1 is both commanded and showing its status bit. Outputs stay in order: PWM implies display, display implies sync, and sync implies pixel clock.
- R4: A sync enable (bit 1) sampled at edge k raises `syncEn` and `status` bit 1 together at edge k+1.
- R5: With guard time N > 0, a display enable (bit 2) arms a frame counter. `dispOut` and `status` bit 2 rise at the edge that samples the N-th `frameEnd` pulse after the enable edge.
- R6: With guard time 0, `dispOut` and `status` bit 2 rise at the edge that samples the display enable.
- R7: A PWM enable (bit 3) sampled at edge k raises `pwmEn` at edge k. PWM status (`status` bit 3) follows `pwmEn` one edge later, in both directions.
- R8: Strobes are write-one. Zero bits change nothing. All set bits in one write are judged against the state before that write, so writing all ones from the off state turns on only the pixel clock.
- R9: A disable of stage i drops the commands of stage i and all later stages at the sampling edge. A clock disable stops sync and display at once, without waiting for a frame end.
- R10: After a sync disable, with the clock still on, `syncEn` and `status` bit 1 stay high until the edge that samples the first `frameEnd` pulse after the disable edge.
- R11: When enable and disable are set for the same stage in one write, the disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enSet | input | 4 | Write-one enable strobes, one bit per stage |
| disSet | input | 4 | Write-one disable strobes, one bit per stage |
| guardFrames | input | GUARD_W | Frames to wait between sync running and display pin assertion |
| frameEnd | input | 1 | One-cycle end-of-frame pulse from the timing generator |
| pixClkEn | output | 1 | Pixel clock gate enable |
| syncEn | output | 1 | Sync engine enable |
| dispOut | output | 1 | Panel display-enable pin |
| pwmEn | output | 1 | Backlight PWM enable |
| status | output | 4 | Stage-running confirmation bits, same order as the strobes |

## Verification
The guard-time check assumes `guardFrames` holds steady while a display enable is pending. It also assumes `frameEnd` is a single-cycle pulse. The bench changes the guard value only while the display stage is off, and issues every frame pulse as one cycle high followed by at least one cycle low. Strobes and frame pulses are driven on the falling clock edge, so each is sampled by exactly one rising edge.

// File: rtl/dpseq_pkg.sv
package dpseq_pkg;
  localparam int NSTAGE = 4;
  localparam int ST_CLK  = 0;
  localparam int ST_SYNC = 1;
  localparam int ST_DISP = 2;
  localparam int ST_PWM  = 3;

  // Control to datapath: command levels plus the strobes the datapath needs.
  typedef struct packed {
    logic [NSTAGE-1:0] on;       // registered stage commands
    logic              killClk;  // clock disable accepted this cycle
    logic              killDisp; // display disable (direct or cascaded)
    logic              armDisp;  // display enable accepted this cycle
  } seqCtl_t;
endpackage

// File: rtl/dpseq_ctrl.sv
module dpseq_ctrl
  import dpseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSTAGE-1:0] enSet,
  input  logic [NSTAGE-1:0] disSet,
  input  logic [NSTAGE-2:0] predStat,
  output seqCtl_t           ctl
);
  logic [NSTAGE-1:0] cmdQ;
  logic [NSTAGE-1:0] clrEff;
  logic [NSTAGE-1:0] ready;
  logic [NSTAGE-1:0] setOk;
  logic              acc;

  // A disable cascades upward to every later stage.
  always_comb begin
    acc = 1'b0;
    for (int i = 0; i < NSTAGE; i++) begin
      acc       = acc | disSet[i];
      clrEff[i] = acc;
    end
  end

  // A stage may start only when its predecessor is commanded and confirmed.
  always_comb begin
    ready[0] = 1'b1;
    for (int i = 1; i < NSTAGE; i++) begin
      ready[i] = cmdQ[i-1] & predStat[i-1];
    end
  end

  assign setOk = enSet & ~cmdQ & ready & ~clrEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdQ <= '0;
    else       cmdQ <= (cmdQ | setOk) & ~clrEff;
  end

  assign ctl.on       = cmdQ;
  assign ctl.killClk  = clrEff[ST_CLK];
  assign ctl.killDisp = clrEff[ST_DISP];
  assign ctl.armDisp  = setOk[ST_DISP];
endmodule

// File: rtl/dpseq_dpath.sv
module dpseq_dpath
  import dpseq_pkg::*;
#(
  parameter int GUARD_W = 4,
  parameter int CLK_SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCtl_t            ctl,
  input  logic               frameEnd,
  input  logic [GUARD_W-1:0] guardFrames,
  output logic [NSTAGE-1:0]  stat
);
  logic [CLK_SYNC_STAGES-1:0] clkPipe;
  logic                       syncRun;
  logic                       dispOn;
  logic                       pwmRun;
  logic [GUARD_W-1:0]         guardCnt;

  // Clock status: synchroniser chain modelling the pixel clock domain latency.
  generate
    if (CLK_SYNC_STAGES == 1) begin : g_pipe1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) clkPipe <= '0;
        else       clkPipe <= ctl.on[ST_CLK];
      end
    end else begin : g_pipeN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) clkPipe <= '0;
        else       clkPipe <= {clkPipe[CLK_SYNC_STAGES-2:0], ctl.on[ST_CLK]};
      end
    end
  endgenerate

  // Sync: starts one edge after command, stops at a frame boundary,
  // or at once if the pixel clock is being removed.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                syncRun <= 1'b0;
    else if (ctl.killClk)     syncRun <= 1'b0;
    else if (ctl.on[ST_SYNC]) syncRun <= 1'b1;
    else if (frameEnd)        syncRun <= 1'b0;
  end

  // Display pin with frame-counted guard delay.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispOn   <= 1'b0;
      guardCnt <= '0;
    end else if (ctl.killDisp) begin
      dispOn   <= 1'b0;
      guardCnt <= '0;
    end else if (ctl.armDisp) begin
      if (guardFrames == '0) dispOn <= 1'b1;
      else                   guardCnt <= guardFrames;
    end else if (ctl.on[ST_DISP] && !dispOn && frameEnd) begin
      if (guardCnt <= GUARD_W'(1)) begin
        dispOn   <= 1'b1;
        guardCnt <= '0;
      end else begin
        guardCnt <= guardCnt - 1'b1;
      end
    end
  end

  // PWM confirmation one edge behind the command.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmRun <= 1'b0;
    else       pwmRun <= ctl.on[ST_PWM];
  end

  assign stat = {pwmRun, dispOn, syncRun, clkPipe[CLK_SYNC_STAGES-1]};
endmodule

// File: rtl/disp_power_seq.sv
module disp_power_seq
  import dpseq_pkg::*;
#(
  parameter int GUARD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         enSet,
  input  logic [3:0]         disSet,
  input  logic [GUARD_W-1:0] guardFrames,
  input  logic               frameEnd,
  output logic               pixClkEn,
  output logic               syncEn,
  output logic               dispOut,
  output logic               pwmEn,
  output logic [3:0]         status
);
  seqCtl_t           ctl;
  logic [NSTAGE-1:0] stat;

  dpseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enSet    (enSet),
    .disSet   (disSet),
    .predStat (stat[NSTAGE-2:0]),
    .ctl      (ctl)
  );

  dpseq_dpath #(.GUARD_W(GUARD_W), .CLK_SYNC_STAGES(2)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .frameEnd    (frameEnd),
    .guardFrames (guardFrames),
    .stat        (stat)
  );

  assign pixClkEn = ctl.on[ST_CLK];
  assign syncEn   = stat[ST_SYNC];
  assign dispOut  = stat[ST_DISP];
  assign pwmEn    = ctl.on[ST_PWM];
  assign status   = stat;
endmodule

// File: rtl/disp_power_seq_chk.sv
module disp_power_seq_chk #(
  parameter int GUARD_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [GUARD_W-1:0] guardFrames,
  input logic               frameEnd,
  input logic               pixClkEn,
  input logic               syncEn,
  input logic               dispOut,
  input logic               pwmEn,
  input logic [3:0]         status
);
  // R3: output ordering
  p_pwm_needs_disp_r3: assert property (@(posedge clk) disable iff (!rstN)
    pwmEn |-> dispOut);
  p_disp_needs_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    dispOut |-> syncEn);
  p_sync_needs_clk_r3: assert property (@(posedge clk) disable iff (!rstN)
    syncEn |-> pixClkEn);
  p_sync_stat_needs_clk_r3: assert property (@(posedge clk) disable iff (!rstN)
    status[1] |-> status[0]);

  // R2: clock status rises two edges after the clock gate
  p_clk_status_lag_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> $past(pixClkEn, 2));

  // R7: PWM status tracks the PWM enable one edge later
  p_pwm_status_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    pwmEn |=> status[3]);
  p_pwm_status_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !pwmEn |=> !status[3]);

  // R10: with the clock kept, sync only stops on a frame boundary
  p_sync_frame_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(syncEn) && pixClkEn) |-> $past(frameEnd));

  // R5: a nonzero guard releases the display only on a frame pulse
  p_guard_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dispOut) && ($past(guardFrames) != '0)) |-> $past(frameEnd));
endmodule

bind disp_power_seq disp_power_seq_chk #(.GUARD_W(GUARD_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .guardFrames (guardFrames),
  .frameEnd    (frameEnd),
  .pixClkEn    (pixClkEn),
  .syncEn      (syncEn),
  .dispOut     (dispOut),
  .pwmEn       (pwmEn),
  .status      (status)
);

// File: tb/disp_power_seq_test.sv
module disp_power_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    enSet = '0;
  logic [3:0]    disSet = '0;
  logic [GW-1:0] guardFrames = GW'(1);
  logic          frameEnd = 1'b0;
  logic          pixClkEn, syncEn, dispOut, pwmEn;
  logic [3:0]    status;

  int nVec = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_power_seq #(.GUARD_W(GW)) uut (
    .clk(clk), .rstN(rstN), .enSet(enSet), .disSet(disSet),
    .guardFrames(guardFrames), .frameEnd(frameEnd),
    .pixClkEn(pixClkEn), .syncEn(syncEn), .dispOut(dispOut),
    .pwmEn(pwmEn), .status(status)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Outputs packed as {pwmEn, dispOut, syncEn, pixClkEn}
  function automatic logic [3:0] pins();
    return {pwmEn, dispOut, syncEn, pixClkEn};
  endfunction

  // One write: strobes sampled by exactly one rising edge; returns after it.
  task automatic write(input logic [3:0] en, input logic [3:0] dis);
    enSet = en; disSet = dis;
    @(negedge clk);
    enSet = '0; disSet = '0;
  endtask

  task automatic frame();
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "pins", 32'(pins()), 32'h0);
    check("R1", "status", 32'(status), 32'h0);
  endtask

  task automatic t_refused();
    write(4'b0010, 4'b0000); idle(2);
    write(4'b0100, 4'b0000); idle(2);
    write(4'b1000, 4'b0000); idle(2);
    check("R3", "pins after out-of-order enables", 32'(pins()), 32'h0);
    check("R3", "status after out-of-order enables", 32'(status), 32'h0);
  endtask

  task automatic t_clock_all_ones();
    write(4'b1111, 4'b0000);
    check("R2", "clock gate at strobe edge", 32'(pixClkEn), 32'h1);
    check("R2", "clock status not yet", 32'(status[0]), 32'h0);
    idle(1);
    check("R2", "clock status one edge later", 32'(status[0]), 32'h0);
    idle(1);
    check("R2", "clock status two edges later", 32'(status[0]), 32'h1);
    check("R8", "all-ones write only starts clock", 32'(pins()), 32'h1);
    check("R8", "status after all-ones write", 32'(status), 32'h1);
    write(4'b0000, 4'b0000); idle(1);
    check("R8", "zero write leaves state", 32'(status), 32'h1);
  endtask

  task automatic t_sync();
    write(4'b0010, 4'b0000);
    check("R4", "sync not at strobe edge", 32'(syncEn), 32'h0);
    idle(1);
    check("R4", "sync one edge later", 32'(syncEn), 32'h1);
    check("R4", "sync status", 32'(status[1]), 32'h1);
  endtask

  task automatic t_guard();
    guardFrames = GW'(2);
    write(4'b0100, 4'b0000);
    idle(3);
    check("R5", "display waits for frames", 32'(dispOut), 32'h0);
    write(4'b1000, 4'b0000); idle(1);
    check("R3", "PWM refused while display pending", 32'(pwmEn), 32'h0);
    frame();
    check("R5", "display after one of two frames", 32'(dispOut), 32'h0);
    idle(2);
    frame();
    check("R5", "display after second frame", 32'(dispOut), 32'h1);
    check("R5", "display status", 32'(status[2]), 32'h1);
  endtask

  task automatic t_pwm();
    write(4'b1000, 4'b0000);
    check("R7", "PWM at strobe edge", 32'(pwmEn), 32'h1);
    check("R7", "PWM status lags", 32'(status[3]), 32'h0);
    idle(1);
    check("R7", "PWM status one edge later", 32'(status[3]), 32'h1);
  endtask

  task automatic t_disp_cascade();
    write(4'b0000, 4'b0100);
    check("R9", "display disable drops display and PWM", 32'(pins()), 32'h3);
    check("R9", "display status drops", 32'(status[2]), 32'h0);
    idle(1);
    check("R7", "PWM status falls one edge later", 32'(status[3]), 32'h0);
  endtask

  task automatic t_sync_drain();
    write(4'b0000, 4'b0010);
    idle(3);
    check("R10", "sync holds until frame end", 32'(syncEn), 32'h1);
    write(4'b0100, 4'b0000); idle(1);
    check("R3", "display refused while sync draining", 32'(dispOut), 32'h0);
    frame();
    check("R10", "sync stops at frame end", 32'(syncEn), 32'h0);
    check("R10", "sync status stops", 32'(status[1]), 32'h0);
  endtask

  task automatic t_guard_zero();
    guardFrames = GW'(0);
    write(4'b0010, 4'b0000); idle(1);
    write(4'b0100, 4'b0000);
    check("R6", "display at strobe edge with zero guard", 32'(dispOut), 32'h1);
    check("R6", "display status with zero guard", 32'(status[2]), 32'h1);
  endtask

  task automatic t_dis_wins();
    write(4'b1000, 4'b1000);
    check("R11", "disable beats enable", 32'(pwmEn), 32'h0);
    idle(1);
    check("R11", "PWM status stays low", 32'(status[3]), 32'h0);
  endtask

  task automatic t_clock_off();
    write(4'b0000, 4'b0001);
    check("R9", "clock disable stops all at once", 32'(pins()), 32'h0);
    check("R9", "clock status still high", 32'(status), 32'h1);
    idle(1);
    check("R2", "clock status one edge after off", 32'(status[0]), 32'h1);
    idle(1);
    check("R2", "clock status two edges after off", 32'(status), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nVec++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_refused();
    t_clock_all_ones();
    t_sync();
    t_guard();
    t_pwm();
    t_disp_cascade();
    t_sync_drain();
    t_guard_zero();
    t_dis_wins();
    t_clock_off();
    idle(2);
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule